// File: doc/BRIEF.md
# Kernel Launch Register Front-End

This block is the host-facing register window that a compute engine uses to accept work. A host first fills a small launch descriptor with byte-addressed bus writes. The descriptor holds a global grid size and a workgroup size for each of three dimensions, plus two 64-bit notification addresses. The host then writes the doorbell register at the start of the window. The block takes a snapshot of the descriptor and runs three iterative ceiling dividers in parallel, one per dimension, to find the workgroup count along each axis. It multiplies the three counts to get the total workgroup count. It then tags the launch with a kernel number and offers the result as a record on a valid/ready interface to a downstream queue.

Every access that falls inside the 4 KiB window gets exactly one response after a fixed, parameterised number of cycles. While a launch is being computed or its record is waiting to be taken, the block reports busy and drops further doorbell writes. Reads of the doorbell location return a sticky flag that shows whether any launch has been handed out since reset.

Top module: `klr_launch_regs`

## Requirements
- R1: A request whose address lies outside [BASE_ADDR, BASE_ADDR+4096) gets no response and has no effect. Every request inside the window gets exactly one resp_valid pulse RESP_LAT cycles after its request cycle, and a write response carries zero data.
- R2: A read at window offset 0 with size code 3 (8 bytes) returns the active flag in bit 0 and zeros above it. A read at offset 0 with any other size code, and any read at offsets 1 to 7, returns zero. Writes at offsets 1 to 7 have no effect.
- R3: An access at offset 8 or above addresses descriptor byte (offset − 8). It moves 2^size_code bytes in little-endian order, with data byte 0 going to the lowest address. Bytes that fall at or beyond DESC_BYTES are dropped on write and read as zero. With the default layout, the 16-bit grid sizes x, y, z sit at offsets 0x08, 0x0A and 0x0C. The 16-bit workgroup sizes x, y, z sit at 0x0E, 0x10 and 0x12. The 64-bit notify address is at 0x18 and the 64-bit counter address is at 0x20.
- R4: A write at offset 0 while busy is low starts a launch, whatever its data. busy is high from the next cycle on.
- R5: The record's count for each dimension is ceil(grid/wg), and a workgroup size of zero counts as one. lr_wg_cnt packs x in the low DIM_W bits, then y, then z. lr_wg_total is the product of the three counts.
- R6: Records carry kernel numbers 0, 1, 2, … in launch order, wrapping modulo 2^KID_W.
- R7: lr_valid rises DIM_W+2 cycles after the launch request cycle. The record stays stable until lr_ready is sampled high, and busy is low in the cycle after that handshake.
- R8: A doorbell write made while busy is high creates no record and uses up no kernel number.
- R9: active is low after reset. It goes high in the cycle the first record is offered and stays high.
- R10: The notify and counter addresses in a record are the descriptor values at the launch request. Descriptor writes made after the launch do not change the pending record.
- R11: While reset is held, resp_valid, busy, lr_valid and active are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Transfer size code, 2^code bytes |
| req_wdata | input | 64 | Write data, byte 0 in bits 7:0 |
| resp_valid | output | 1 | Response pulse |
| resp_rdata | output | 64 | Read data (zero for writes) |
| busy | output | 1 | Launch in progress, doorbell ignored |
| active | output | 1 | Sticky: a launch record has been offered |
| lr_valid | output | 1 | Launch record valid |
| lr_ready | input | 1 | Downstream accepts the record |
| lr_kid | output | KID_W | Kernel number |
| lr_wg_cnt | output | 3*DIM_W | Workgroup counts z:y:x |
| lr_wg_total | output | 3*DIM_W | Total workgroup count |
| lr_notify_addr | output | 64 | Notify address snapshot |
| lr_count_addr | output | 64 | Counter address snapshot |

## Verification
A fault in the descriptor bytes shows up in the read data of the next read response, RESP_LAT cycles after that read, or in the count fields of the next record. A divider that stops a step early or late, or gets the rounding wrong, moves the cycle in which lr_valid rises or gives a wrong per-axis count. Either appears at the DIM_W+2 boundary. A kernel-number counter that slips, or one that advances on a dropped doorbell, is caught on the very next record. Since every output is compared with a behavioural model on every cycle, the first cycle in which the ports diverge is the one reported.

// File: rtl/klr_pkg.sv
package klr_pkg;
  localparam int unsigned WIN_BYTES = 4096;
  localparam int unsigned WIN_AW    = 12;
  localparam int unsigned DESC_OFF  = 8;
  localparam int unsigned BUS_DW    = 64;
  localparam int unsigned BUS_BYTES = BUS_DW / 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DIV  = 2'd1,
    PH_PUSH = 2'd2
  } phase_t;

  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/klr_desc_store.sv
module klr_desc_store
  import klr_pkg::*;
#(
  parameter int DESC_BYTES  = 32,
  parameter int DIM_W       = 16,
  parameter int NOTIFY_POS  = 16,
  parameter int CNTADDR_POS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WIN_AW-1:0]   acc_rel,
  input  logic [3:0]          acc_nb,
  input  logic [BUS_DW-1:0]   wr_data,
  output logic [BUS_DW-1:0]   rd_data,
  output logic [3*DIM_W-1:0]  grid_o,
  output logic [3*DIM_W-1:0]  wgsz_o,
  output logic [63:0]         notify_o,
  output logic [63:0]         cntaddr_o
);
  localparam int IDX_W = $clog2(DESC_BYTES);
  localparam int RW    = WIN_AW + 1;
  localparam int DB    = DIM_W / 8;
  typedef logic [RW-1:0] rel_t;

  logic [7:0]       mem [DESC_BYTES];
  rel_t             full  [BUS_BYTES];
  logic [IDX_W-1:0] b_idx [BUS_BYTES];
  logic             b_ok  [BUS_BYTES];

  always_comb begin
    for (int i = 0; i < BUS_BYTES; i++) begin
      full[i]  = {1'b0, acc_rel} + rel_t'(i);
      b_ok[i]  = (4'(i) < acc_nb) && (full[i] < rel_t'(DESC_BYTES));
      b_idx[i] = full[i][IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DESC_BYTES; k++) mem[k] <= 8'h00;
    end else if (wr_en) begin
      for (int i = 0; i < BUS_BYTES; i++)
        if (b_ok[i]) mem[b_idx[i]] <= wr_data[8*i +: 8];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < BUS_BYTES; i++)
      if (b_ok[i]) rd_data[8*i +: 8] = mem[b_idx[i]];
  end

  genvar d, b;
  generate
    for (d = 0; d < 3; d++) begin : g_dim
      for (b = 0; b < DB; b++) begin : g_byte
        assign grid_o[d*DIM_W + 8*b +: 8] = mem[d*DB + b];
        assign wgsz_o[d*DIM_W + 8*b +: 8] = mem[(3+d)*DB + b];
      end
    end
    for (b = 0; b < 8; b++) begin : g_addr
      assign notify_o[8*b +: 8]  = mem[NOTIFY_POS + b];
      assign cntaddr_o[8*b +: 8] = mem[CNTADDR_POS + b];
    end
  endgenerate
endmodule

// File: rtl/klr_resp_pipe.sv
module klr_resp_pipe #(
  parameter int LAT = 2,
  parameter int DW  = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [DW-1:0] in_d,
  output logic          out_v,
  output logic [DW-1:0] out_d
);
  logic          v_q [LAT];
  logic [DW-1:0] d_q [LAT];

  genvar k;
  generate
    for (k = 0; k < LAT; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) v_q[0] <= 1'b0;
          else     v_q[0] <= in_v;
          d_q[0] <= in_d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) v_q[k] <= 1'b0;
          else     v_q[k] <= v_q[k-1];
          d_q[k] <= d_q[k-1];
        end
      end
    end
  endgenerate

  assign out_v = v_q[LAT-1];
  assign out_d = d_q[LAT-1];
endmodule

// File: rtl/klr_ceil_div.sv
module klr_ceil_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W + 1);
  localparam int W2 = 2 * W;
  typedef logic [W2-1:0] wide_t;

  logic [W-1:0]  quo_q, den_q, num_q, res_q, rem_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    r_sh;
  logic          ge;
  logic [W-1:0]  r_nx, q_nx;

  always_comb begin
    r_sh = {rem_q, quo_q[W-1]};
    ge   = r_sh >= {1'b0, den_q};
    r_nx = ge ? W'(r_sh - {1'b0, den_q}) : r_sh[W-1:0];
    q_nx = {quo_q[W-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      rem_q  <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        quo_q <= num;
        num_q <= num;
        den_q <= (den == '0) ? W'(1) : den;
        rem_q <= '0;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= r_nx;
        quo_q <= q_nx;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          res_q  <= q_nx + W'(r_nx != '0);
        end
      end
    end
  end

  assign done   = done_q;
  assign result = res_q;

  // R5: result is the smallest multiple count covering the numerator
  assert_ceil_bound_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ((wide_t'(res_q) * wide_t'(den_q) >= wide_t'(num_q)) &&
                ((res_q == '0) || (wide_t'(res_q - W'(1)) * wide_t'(den_q) < wide_t'(num_q)))));

  // R8: a new division never starts while one is running
  assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
    start |-> !run_q);
endmodule

// File: rtl/klr_launch_regs.sv
module klr_launch_regs
  import klr_pkg::*;
#(
  parameter int                 ADDR_W      = 32,
  parameter logic [ADDR_W-1:0]  BASE_ADDR   = 'h0001_0000,
  parameter int                 DIM_W       = 16,
  parameter int                 DESC_BYTES  = 32,
  parameter int                 NOTIFY_POS  = 16,
  parameter int                 CNTADDR_POS = 24,
  parameter int                 RESP_LAT    = 2,
  parameter int                 KID_W       = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic [63:0]         req_wdata,
  output logic                resp_valid,
  output logic [63:0]         resp_rdata,
  output logic                busy,
  output logic                active,
  output logic                lr_valid,
  input  logic                lr_ready,
  output logic [KID_W-1:0]    lr_kid,
  output logic [3*DIM_W-1:0]  lr_wg_cnt,
  output logic [3*DIM_W-1:0]  lr_wg_total,
  output logic [63:0]         lr_notify_addr,
  output logic [63:0]         lr_count_addr
);
  localparam int CNT_W = 3 * DIM_W;

  // ---------------- address decode ----------------
  logic [ADDR_W-1:0] off_full;
  logic [WIN_AW-1:0] off, rel;
  logic              in_win, acc, at_launch, in_desc;
  logic [3:0]        nb;

  assign off_full  = req_addr - BASE_ADDR;
  assign in_win    = (req_addr >= BASE_ADDR) && (off_full < ADDR_W'(WIN_BYTES));
  assign off       = off_full[WIN_AW-1:0];
  assign acc       = req_valid && in_win;
  assign at_launch = (off == '0);
  assign in_desc   = (off >= WIN_AW'(DESC_OFF));
  assign rel       = off - WIN_AW'(DESC_OFF);
  assign nb        = size_bytes(req_size);

  // ---------------- state ----------------
  phase_t             phase_q;
  logic               active_q;
  logic [KID_W-1:0]   kid_ctr_q;
  logic               launch_go;

  assign busy      = (phase_q != PH_IDLE);
  assign lr_valid  = (phase_q == PH_PUSH);
  assign active    = active_q;
  assign launch_go = acc && req_write && at_launch && (phase_q == PH_IDLE);

  // ---------------- descriptor ----------------
  logic [63:0]        desc_rd;
  logic [CNT_W-1:0]   grid_v, wgsz_v;
  logic [63:0]        notify_v, cntaddr_v;

  klr_desc_store #(
    .DESC_BYTES (DESC_BYTES),
    .DIM_W      (DIM_W),
    .NOTIFY_POS (NOTIFY_POS),
    .CNTADDR_POS(CNTADDR_POS)
  ) u_desc (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (acc && req_write && in_desc),
    .acc_rel  (rel),
    .acc_nb   (nb),
    .wr_data  (req_wdata),
    .rd_data  (desc_rd),
    .grid_o   (grid_v),
    .wgsz_o   (wgsz_v),
    .notify_o (notify_v),
    .cntaddr_o(cntaddr_v)
  );

  // ---------------- response path ----------------
  logic [63:0] rd_mux, resp_in;

  always_comb begin
    if (at_launch)    rd_mux = (req_size == 2'd3) ? {{63{1'b0}}, active_q} : '0;
    else if (in_desc) rd_mux = desc_rd;
    else              rd_mux = '0;
    resp_in = req_write ? '0 : rd_mux;
  end

  klr_resp_pipe #(.LAT(RESP_LAT), .DW(64)) u_resp (
    .clk  (clk),
    .rst  (rst),
    .in_v (acc),
    .in_d (resp_in),
    .out_v(resp_valid),
    .out_d(resp_rdata)
  );

  // ---------------- dividers ----------------
  logic [2:0]       div_done;
  logic [CNT_W-1:0] div_res;

  genvar d;
  generate
    for (d = 0; d < 3; d++) begin : g_div
      klr_ceil_div #(.W(DIM_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (launch_go),
        .num   (grid_v[d*DIM_W +: DIM_W]),
        .den   (wgsz_v[d*DIM_W +: DIM_W]),
        .done  (div_done[d]),
        .result(div_res[d*DIM_W +: DIM_W])
      );
    end
  endgenerate

  // ---------------- launch control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q        <= PH_IDLE;
      active_q       <= 1'b0;
      kid_ctr_q      <= '0;
      lr_kid         <= '0;
      lr_wg_cnt      <= '0;
      lr_wg_total    <= '0;
      lr_notify_addr <= '0;
      lr_count_addr  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (launch_go) begin
          phase_q        <= PH_DIV;
          lr_notify_addr <= notify_v;
          lr_count_addr  <= cntaddr_v;
        end
        PH_DIV: if (&div_done) begin
          phase_q     <= PH_PUSH;
          lr_wg_cnt   <= div_res;
          lr_wg_total <= CNT_W'(div_res[0 +: DIM_W]) *
                         CNT_W'(div_res[DIM_W +: DIM_W]) *
                         CNT_W'(div_res[2*DIM_W +: DIM_W]);
          lr_kid      <= kid_ctr_q;
          kid_ctr_q   <= kid_ctr_q + KID_W'(1);
          active_q    <= 1'b1;
        end
        PH_PUSH: if (lr_ready) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic             seen_q;
  logic [KID_W-1:0] last_kid_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q     <= 1'b0;
      last_kid_q <= '0;
    end else if (lr_valid && lr_ready) begin
      seen_q     <= 1'b1;
      last_kid_q <= lr_kid;
    end
  end

  assert_launch_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && in_win && at_launch && !busy) |=> busy);

  assert_hold_record_R7: assert property (@(posedge clk) disable iff (rst)
    (lr_valid && !lr_ready) |=> (lr_valid && $stable(lr_kid) && $stable(lr_wg_total) &&
                                 $stable(lr_wg_cnt) && $stable(lr_notify_addr)));

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    (lr_valid && lr_ready) |=> !busy);

  assert_active_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    active |=> active);

  assert_active_at_push_R9: assert property (@(posedge clk) disable iff (rst)
    lr_valid |-> active);

  assert_total_zero_R5: assert property (@(posedge clk) disable iff (rst)
    lr_valid |-> ((lr_wg_total == '0) ==
                  ((lr_wg_cnt[0 +: DIM_W] == '0) || (lr_wg_cnt[DIM_W +: DIM_W] == '0) ||
                   (lr_wg_cnt[2*DIM_W +: DIM_W] == '0))));

  assert_kid_step_R6: assert property (@(posedge clk) disable iff (rst)
    (lr_valid && !$past(lr_valid) && seen_q) |-> (lr_kid == last_kid_q + KID_W'(1)));
endmodule

// File: tb/sim_klr_launch_regs.sv
module sim_klr_launch_regs;
  localparam int          LAT   = 2;
  localparam int          DIMW  = 16;
  localparam int          DESCB = 32;
  localparam int          KW    = 8;
  localparam logic [31:0] BASE  = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        lr_ready = 1'b0;
  logic        resp_valid, busy, active, lr_valid;
  logic [63:0] resp_rdata, lr_notify_addr, lr_count_addr;
  logic [KW-1:0]     lr_kid;
  logic [3*DIMW-1:0] lr_wg_cnt, lr_wg_total;

  always #5 clk = ~clk;

  klr_launch_regs #(
    .ADDR_W(32), .BASE_ADDR(BASE), .DIM_W(DIMW), .DESC_BYTES(DESCB),
    .NOTIFY_POS(16), .CNTADDR_POS(24), .RESP_LAT(LAT), .KID_W(KW)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .busy(busy), .active(active),
    .lr_valid(lr_valid), .lr_ready(lr_ready), .lr_kid(lr_kid), .lr_wg_cnt(lr_wg_cnt),
    .lr_wg_total(lr_wg_total), .lr_notify_addr(lr_notify_addr), .lr_count_addr(lr_count_addr)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit               m_active;
  int               m_phase, m_cnt, m_kid, m_ekid, rec_exp, rec_seen;
  byte unsigned     m_desc [DESCB];
  bit               m_pv [LAT];
  longint unsigned  m_pd [LAT];
  string            m_pt [LAT];
  longint unsigned  m_ecnt [3];
  longint unsigned  m_etot, m_enot, m_ecad;

  function automatic longint unsigned desc_val(input int pos, input int n);
    longint unsigned v = 0;
    for (int i = n - 1; i >= 0; i--) v = (v << 8) | longint'(m_desc[pos + i]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_active = 0; m_phase = 0; m_cnt = 0; m_kid = 0; rec_exp = 0; rec_seen = 0;
      for (int i = 0; i < DESCB; i++) m_desc[i] = 0;
      for (int k = 0; k < LAT; k++) begin m_pv[k] = 0; m_pd[k] = 0; m_pt[k] = "R1"; end
    end else begin
      bit hit, launch;
      int off, nbytes;
      longint unsigned rd;
      string tag;
      if (lr_valid && lr_ready) rec_seen++;
      hit = req_valid && (req_addr >= BASE) && (req_addr < BASE + 32'd4096);
      off = int'(req_addr - BASE);
      nbytes = 1 << req_size;
      launch = 0; rd = 0; tag = "R1";
      if (hit && !req_write) begin
        if (off == 0) begin rd = (req_size == 2'd3) ? longint'(m_active) : 0; tag = "R2"; end
        else if (off < 8) tag = "R2";
        else begin
          tag = "R3";
          for (int i = 0; i < nbytes; i++)
            if (off - 8 + i < DESCB) rd |= longint'(m_desc[off - 8 + i]) << (8 * i);
        end
      end
      if (hit && req_write) begin
        if (off == 0) launch = (m_phase == 0);
        else if (off >= 8)
          for (int i = 0; i < nbytes; i++)
            if (off - 8 + i < DESCB) m_desc[off - 8 + i] = req_wdata[8*i +: 8];
      end
      for (int k = LAT - 1; k > 0; k--) begin
        m_pv[k] = m_pv[k-1]; m_pd[k] = m_pd[k-1]; m_pt[k] = m_pt[k-1];
      end
      m_pv[0] = hit; m_pd[0] = rd; m_pt[0] = tag;
      case (m_phase)
        0: if (launch) begin
          longint unsigned g, w;
          m_etot = 1;
          for (int d = 0; d < 3; d++) begin
            g = desc_val(2*d, 2);
            w = desc_val(6 + 2*d, 2);
            if (w == 0) w = 1;
            m_ecnt[d] = (g + w - 1) / w;
            m_etot = m_etot * m_ecnt[d];
          end
          m_enot = desc_val(16, 8);
          m_ecad = desc_val(24, 8);
          m_phase = 1; m_cnt = DIMW + 1;
        end
        1: begin
          m_cnt--;
          if (m_cnt == 0) begin
            m_phase = 2; m_active = 1; m_ekid = m_kid;
            m_kid = (m_kid + 1) % (1 << KW); rec_exp++;
          end
        end
        default: if (lr_ready) m_phase = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (started && !rst) begin
      chk(resp_valid == m_pv[LAT-1], "R1", "resp_valid", longint'(resp_valid), longint'(m_pv[LAT-1]));
      if (m_pv[LAT-1] && resp_valid)
        chk(resp_rdata == m_pd[LAT-1], m_pt[LAT-1], "resp_rdata", resp_rdata, m_pd[LAT-1]);
      chk(busy == (m_phase != 0), "R4", "busy", longint'(busy), longint'(m_phase != 0));
      chk(lr_valid == (m_phase == 2), "R7", "lr_valid", longint'(lr_valid), longint'(m_phase == 2));
      chk(active == m_active, "R9", "active", longint'(active), longint'(m_active));
      if (m_phase == 2 && lr_valid) begin
        chk(lr_kid == m_ekid[KW-1:0], "R6", "lr_kid", longint'(lr_kid), longint'(m_ekid));
        for (int d = 0; d < 3; d++)
          chk(lr_wg_cnt[d*DIMW +: DIMW] == m_ecnt[d][DIMW-1:0], "R5", "lr_wg_cnt",
              longint'(lr_wg_cnt[d*DIMW +: DIMW]), m_ecnt[d]);
        chk(lr_wg_total == m_etot[3*DIMW-1:0], "R5", "lr_wg_total", longint'(lr_wg_total), m_etot);
        chk(lr_notify_addr == m_enot, "R10", "lr_notify_addr", lr_notify_addr, m_enot);
        chk(lr_count_addr == m_ecad, "R10", "lr_count_addr", lr_count_addr, m_ecad);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus(input bit wr, input logic [31:0] a, input logic [1:0] sz, input logic [63:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_dims(input int g0, g1, g2, w0, w1, w2);
    bus(1, BASE + 32'h08, 2'd1, 64'(g0));
    bus(1, BASE + 32'h0A, 2'd1, 64'(g1));
    bus(1, BASE + 32'h0C, 2'd1, 64'(g2));
    bus(1, BASE + 32'h0E, 2'd1, 64'(w0));
    bus(1, BASE + 32'h10, 2'd1, 64'(w1));
    bus(1, BASE + 32'h12, 2'd1, 64'(w2));
  endtask

  task automatic launch_take(input int g0, g1, g2, w0, w1, w2);
    set_dims(g0, g1, g2, w0, w1, w2);
    lr_ready = 1;
    bus(1, BASE, 2'd0, 64'hDEAD);
    idle(DIMW + 6);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "WD", "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    // R11: reset state
    chk(!resp_valid && !busy && !lr_valid && !active, "R11", "reset outputs",
        {resp_valid, busy, lr_valid, active}, 0);
    rst = 0;
    started = 1;
    idle(2);
    // R2: doorbell reads before any launch
    bus(0, BASE, 2'd3, 0);
    bus(0, BASE, 2'd2, 0);
    bus(0, BASE + 32'h4, 2'd2, 0);
    bus(1, BASE + 32'h4, 2'd2, 64'hFFFF_FFFF);
    // R3: descriptor fill and read-back
    set_dims(100, 7, 1, 16, 0, 1);
    bus(1, BASE + 32'h18, 2'd3, 64'h1122_3344_5566_7788);
    bus(1, BASE + 32'h20, 2'd3, 64'hA0B0_C0D0_E0F0_0102);
    bus(0, BASE + 32'h08, 2'd3, 0);
    bus(0, BASE + 32'h19, 2'd1, 0);
    bus(0, BASE + 32'h26, 2'd3, 0);
    bus(1, BASE + 32'h28, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    bus(0, BASE + 32'h28, 2'd3, 0);
    bus(1, BASE + 32'h24, 2'd3, 64'h9999_8888_7777_6666);
    bus(0, BASE + 32'h20, 2'd3, 0);
    // R1: outside the window
    bus(0, BASE - 32'd8, 2'd3, 0);
    bus(1, BASE + 32'd4096, 2'd0, 0);
    bus(0, BASE + 32'd4095, 2'd0, 0);
    idle(4);
    // R4 / R7 / R8 / R10: launch with held ready
    lr_ready = 0;
    bus(1, BASE, 2'd3, 64'h0);
    idle(3);
    bus(1, BASE, 2'd3, 64'h1);                       // R8: dropped doorbell
    bus(1, BASE + 32'h18, 2'd3, 64'h0BAD_0BAD_0BAD_0BAD); // R10: after snapshot
    for (int i = 0; i < 200 && !lr_valid; i++) @(negedge clk);
    idle(5);
    bus(1, BASE, 2'd0, 0);                           // R8: doorbell during hold
    bus(1, BASE + 32'h20, 2'd3, 64'h0);              // R10
    lr_ready = 1;
    idle(3);
    bus(0, BASE, 2'd3, 0);                           // R2: active now set
    idle(3);
    // R5 / R6: several launches with ready held high
    launch_take(0, 5, 5, 1, 1, 1);
    launch_take(65535, 65535, 65535, 1, 1, 1);
    launch_take(65535, 65535, 3, 65535, 2, 4);
    launch_take(1, 1, 1, 65535, 65535, 65535);
    launch_take(17, 33, 64, 16, 32, 64);
    launch_take(5, 0, 9, 0, 0, 2);
    // back-to-back doorbells: second one dropped (R8)
    lr_ready = 1;
    bus(1, BASE, 2'd0, 0);
    bus(1, BASE, 2'd0, 0);
    idle(DIMW + 8);
    chk(rec_seen == rec_exp, "R8", "records taken", longint'(rec_seen), longint'(rec_exp));
    chk(rec_exp == 8, "R8", "launch count", longint'(rec_exp), 8);
    summary();
    $finish;
  end
endmodule